// File: doc/BRIEF.md
# Circular Event Queue Writer

This block posts interrupt event notifications into circular queues held in system memory. There is one queue for every pairing of a notification target and a priority level, and each queue has its own base address, its own size and its own enable. For each queue the block also tracks where the next entry goes and the current generation bit. When an enqueue request arrives carrying a queue index and a 31-bit event payload, the block does the following:

- builds a 32-bit entry;
- issues a single word write on a plain memory write port;
- on the next cycle, pulses a notify line toward the presenter.

The generation bit in each entry flips every time the queue wraps. A consumer can therefore tell fresh entries from stale ones without sharing a read pointer with the writer. Setting a queue's size to zero switches that queue off. A clear command wipes every queue in one cycle.

The queue index is laid out as `{target, priority}`, with priority in the low 3 bits. Priority 7 is reserved and cannot be used for queueing.

Top module: `eq_writer`

## Requirements
- R1: Each written word is `{gen, data}`: bit 31 is the queue's generation bit and bits 30:0 are the request's event data.
- R2: The write address is the queue base plus 4 times the queue's write index. The write index starts at 0 and advances by one for every accepted enqueue.
- R3: A queue configured with size code L (log2 of its byte size) holds 2^(L-2) entries. After the last slot is written, the index returns to 0 and the generation bit inverts. The generation bit is 1 right after configuration.
- R4: Every write is followed on the next cycle by a one-cycle `notify` pulse, and `notify_qidx` carries that write's queue index.
- R5: An enqueue to a queue whose size code is 0 (never configured, cleared, or configured with 0) performs no write. It raises `enq_err` for one cycle. Exactly one of `mem_we` or `enq_err` follows every enqueue request.
- R6: Priority 7 (`qidx[2:0] == 7`) is reserved. An enqueue to it is dropped with `enq_err`, and a configuration of it is refused with `cfg_err`.
- R7: A nonzero size code outside `[MIN_LOG2, MAX_LOG2]` is refused with a one-cycle `cfg_err`, and the queue keeps its previous base, size, index and generation.
- R8: `clear_all` disables every queue in one cycle. An enqueue in the same cycle as `clear_all` is dropped with `enq_err`.
- R9: An accepted configuration restarts the queue at index 0 with generation 1. An enqueue to the same queue in the same cycle uses the old settings.
- R10: After reset, all outputs are 0 and every queue is disabled.
- R11: `mem_we`, `mem_addr` and `mem_wdata` are registered and appear one cycle after the enqueue request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Disable and rewind every queue |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qidx | input | TGT_W+3 | Queue being configured, `{target, priority}` |
| cfg_base | input | ADDR_W | Queue base byte address (aligned to queue size) |
| cfg_log2 | input | SZ_W | Log2 of queue byte size; 0 disables |
| enq_valid | input | 1 | Enqueue request |
| enq_qidx | input | TGT_W+3 | Destination queue, `{target, priority}` |
| enq_data | input | 31 | Event payload |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | 32 | Entry word |
| notify | output | 1 | Notification pulse to the presenter |
| notify_qidx | output | TGT_W+3 | Queue that was just written |
| enq_err | output | 1 | Enqueue dropped |
| cfg_err | output | 1 | Configuration refused |

## Verification
A corrupted write index shows up as a wrong `mem_addr` on the very next write to that queue. A stuck or mistimed generation toggle shows up in bit 31 of the first entry written after a wrap. A lost or spurious enable shows up as `mem_we` and `enq_err` trading places one cycle after the request. Because the bench model tracks every queue independently and compares the outputs on every clock, any such fault becomes visible on the first enqueue that touches the damaged queue.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
  localparam int PRIO_W     = 3;
  localparam int RSVD_PRIO  = 7;
  localparam int WORD_W     = 32;
  localparam int DATA_W     = 31;
  localparam int BYTE_SHIFT = 2;
endpackage

// File: rtl/eqw_cfg_check.sv
module eqw_cfg_check
  import eqw_pkg::*;
#(
  parameter int QI_W     = 5,
  parameter int SZ_W     = 5,
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 12
) (
  input  logic [QI_W-1:0] qidx,
  input  logic [SZ_W-1:0] lg,
  output logic            ok
);
  localparam logic [SZ_W-1:0]   LG_MIN = SZ_W'(MIN_LOG2);
  localparam logic [SZ_W-1:0]   LG_MAX = SZ_W'(MAX_LOG2);
  localparam logic [PRIO_W-1:0] PR_RS  = PRIO_W'(RSVD_PRIO);

  logic prio_ok, size_ok;

  always_comb begin
    prio_ok = (qidx[PRIO_W-1:0] != PR_RS);
    size_ok = (lg == '0) || ((lg >= LG_MIN) && (lg <= LG_MAX));
    ok      = prio_ok && size_ok;
  end
endmodule

// File: rtl/eqw_entry_fmt.sv
module eqw_entry_fmt
  import eqw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SZ_W     = 5,
  parameter int MAX_LOG2 = 12,
  localparam int IDX_W   = MAX_LOG2 - BYTE_SHIFT
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   lg,
  input  logic [IDX_W-1:0]  idx,
  input  logic              gen,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word,
  output logic              last
);
  localparam logic [SZ_W-1:0] LG_MAX = SZ_W'(MAX_LOG2);

  logic [IDX_W-1:0] slot_mask;

  always_comb begin
    slot_mask = {IDX_W{1'b1}} >> (LG_MAX - lg);
    last      = (idx == slot_mask);
    addr      = base + ADDR_W'({idx, {BYTE_SHIFT{1'b0}}});
    word      = {gen, data};
  end
endmodule

// File: rtl/eqw_queue_state.sv
module eqw_queue_state #(
  parameter int QI_W   = 5,
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 5,
  parameter int IDX_W  = 10,
  localparam int NQ    = 1 << QI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_all,
  input  logic              cfg_apply,
  input  logic [QI_W-1:0]   cfg_q,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_lg,
  input  logic              adv,
  input  logic              adv_last,
  input  logic [QI_W-1:0]   adv_q,
  input  logic [QI_W-1:0]   rd_q,
  output logic [ADDR_W-1:0] rd_base,
  output logic [SZ_W-1:0]   rd_lg,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_gen
);
  logic [ADDR_W-1:0] base_r [NQ];
  logic [SZ_W-1:0]   lg_r   [NQ];
  logic [IDX_W-1:0]  idx_r  [NQ];
  logic              gen_r  [NQ];

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      for (int q = 0; q < NQ; q++) begin
        base_r[q] <= '0;
        lg_r[q]   <= '0;
        idx_r[q]  <= '0;
        gen_r[q]  <= 1'b0;
      end
    end else begin
      if (adv) begin
        if (adv_last) begin
          idx_r[adv_q] <= '0;
          gen_r[adv_q] <= ~gen_r[adv_q];
        end else begin
          idx_r[adv_q] <= idx_r[adv_q] + 1'b1;
        end
      end
      if (cfg_apply) begin
        base_r[cfg_q] <= cfg_base;
        lg_r[cfg_q]   <= cfg_lg;
        idx_r[cfg_q]  <= '0;
        gen_r[cfg_q]  <= 1'b1;
      end
    end
  end

  assign rd_base = base_r[rd_q];
  assign rd_lg   = lg_r[rd_q];
  assign rd_idx  = idx_r[rd_q];
  assign rd_gen  = gen_r[rd_q];

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && adv_last && !clear_all && !(cfg_apply && cfg_q == adv_q))
    |=> (idx_r[$past(adv_q)] == '0) && (gen_r[$past(adv_q)] != $past(gen_r[adv_q])));

  assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_apply && !clear_all) |=> (idx_r[$past(cfg_q)] == '0) && gen_r[$past(cfg_q)]);

  for (genvar g = 0; g < NQ; g++) begin : g_clr_chk
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      clear_all |=> (lg_r[g] == '0));
  end
endmodule

// File: rtl/eq_writer.sv
module eq_writer
  import eqw_pkg::*;
#(
  parameter int TGT_W    = 2,
  parameter int ADDR_W   = 32,
  parameter int SZ_W     = 5,
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear_all,
  input  logic                      cfg_we,
  input  logic [TGT_W+PRIO_W-1:0]   cfg_qidx,
  input  logic [ADDR_W-1:0]         cfg_base,
  input  logic [SZ_W-1:0]           cfg_log2,
  input  logic                      enq_valid,
  input  logic [TGT_W+PRIO_W-1:0]   enq_qidx,
  input  logic [DATA_W-1:0]         enq_data,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_wdata,
  output logic                      notify,
  output logic [TGT_W+PRIO_W-1:0]   notify_qidx,
  output logic                      enq_err,
  output logic                      cfg_err
);
  localparam int QI_W  = TGT_W + PRIO_W;
  localparam int IDX_W = MAX_LOG2 - BYTE_SHIFT;
  localparam logic [PRIO_W-1:0] PR_RS  = PRIO_W'(RSVD_PRIO);
  localparam logic [SZ_W-1:0]   LG_MAX = SZ_W'(MAX_LOG2);

  logic [ADDR_W-1:0] q_base;
  logic [SZ_W-1:0]   q_lg;
  logic [IDX_W-1:0]  q_idx;
  logic              q_gen;
  logic [ADDR_W-1:0] nxt_addr;
  logic [WORD_W-1:0] nxt_word;
  logic              slot_last;
  logic              cfg_ok, cfg_apply, accept;
  logic [QI_W-1:0]   wr_q;

  eqw_cfg_check #(
    .QI_W(QI_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
  ) u_cfg_check (
    .qidx(cfg_qidx), .lg(cfg_log2), .ok(cfg_ok)
  );

  assign accept    = enq_valid && !clear_all && (q_lg != '0)
                     && (enq_qidx[PRIO_W-1:0] != PR_RS);
  assign cfg_apply = cfg_we && cfg_ok && !clear_all;

  eqw_queue_state #(
    .QI_W(QI_W), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W)
  ) u_state (
    .clk(clk), .rst(rst), .clear_all(clear_all),
    .cfg_apply(cfg_apply), .cfg_q(cfg_qidx), .cfg_base(cfg_base), .cfg_lg(cfg_log2),
    .adv(accept), .adv_last(slot_last), .adv_q(enq_qidx),
    .rd_q(enq_qidx), .rd_base(q_base), .rd_lg(q_lg), .rd_idx(q_idx), .rd_gen(q_gen)
  );

  eqw_entry_fmt #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MAX_LOG2(MAX_LOG2)
  ) u_fmt (
    .base(q_base), .lg(q_lg), .idx(q_idx), .gen(q_gen), .data(enq_data),
    .addr(nxt_addr), .word(nxt_word), .last(slot_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      wr_q        <= '0;
      notify      <= 1'b0;
      notify_qidx <= '0;
      enq_err     <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      mem_we  <= accept;
      enq_err <= enq_valid && !accept;
      cfg_err <= cfg_we && !cfg_ok;
      notify  <= mem_we;
      if (accept) begin
        mem_addr  <= nxt_addr;
        mem_wdata <= nxt_word;
        wr_q      <= enq_qidx;
      end
      if (mem_we) notify_qidx <= wr_q;
    end
  end

  assert_write_timing_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(enq_valid));

  assert_notify_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> notify);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    enq_valid |=> (mem_we != enq_err));

  assert_rsvd_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && enq_qidx[PRIO_W-1:0] == PR_RS) |=> (enq_err && !mem_we));

  assert_cfg_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_log2 > LG_MAX) |=> cfg_err);
endmodule

// File: tb/test_eq_writer.sv
module test_eq_writer;
  localparam int QI = 5;
  localparam int NQ = 32;
  localparam int MINL = 4;
  localparam int MAXL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear_all = 1'b0, cfg_we = 1'b0, enq_valid = 1'b0;
  logic [QI-1:0] cfg_qidx = '0, enq_qidx = '0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_log2 = '0;
  logic [30:0] enq_data = '0;
  logic mem_we, notify, enq_err, cfg_err;
  logic [31:0] mem_addr, mem_wdata;
  logic [QI-1:0] notify_qidx;

  always #2 clk = ~clk;

  eq_writer i_eq_writer (
    .clk(clk), .rst(rst), .clear_all(clear_all), .cfg_we(cfg_we), .cfg_qidx(cfg_qidx),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2), .enq_valid(enq_valid), .enq_qidx(enq_qidx),
    .enq_data(enq_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .notify(notify), .notify_qidx(notify_qidx), .enq_err(enq_err), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;

  // reference model
  logic [31:0] m_base [NQ];
  int          m_lg   [NQ];
  int          m_idx  [NQ];
  bit          m_gen  [NQ];
  logic e_we = 0, e_notify = 0, e_err = 0, e_cerr = 0;
  logic [31:0] e_addr = 0, e_wdata = 0;
  logic [QI-1:0] e_mq = 0, e_nq = 0;

  task automatic model_clear();
    for (int q = 0; q < NQ; q++) begin
      m_base[q] = 0; m_lg[q] = 0; m_idx[q] = 0; m_gen[q] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_clear();
      e_we = 0; e_notify = 0; e_err = 0; e_cerr = 0;
    end else begin
      int q;
      bit acc, cok;
      e_notify = e_we;
      if (e_we) e_nq = e_mq;
      q = int'(enq_qidx);
      acc = enq_valid && !clear_all && m_lg[q] != 0 && (q % 8) != 7;
      e_we = acc;
      e_err = enq_valid && !acc;
      if (acc) begin
        e_addr  = m_base[q] + 32'(4 * m_idx[q]);
        e_wdata = {m_gen[q], enq_data};
        e_mq    = enq_qidx;
        m_idx[q]++;
        if (m_idx[q] == (1 << (m_lg[q] - 2))) begin
          m_idx[q] = 0;
          m_gen[q] = !m_gen[q];
        end
      end
      cok = (int'(cfg_qidx) % 8 != 7) &&
            (cfg_log2 == 0 || (int'(cfg_log2) >= MINL && int'(cfg_log2) <= MAXL));
      e_cerr = cfg_we && !cok;
      if (clear_all) model_clear();
      else if (cfg_we && cok) begin
        q = int'(cfg_qidx);
        m_base[q] = cfg_base; m_lg[q] = int'(cfg_log2); m_idx[q] = 0; m_gen[q] = 1;
      end
    end
  end

  always @(negedge clk) begin
    bit bad;
    bad = 0;
    n_chk++;
    if (mem_we !== e_we) begin bad = 1;
      $display("FAIL R11 mem_we act=%0b exp=%0b t=%0t", mem_we, e_we, $time); end
    if (enq_err !== e_err) begin bad = 1;
      $display("FAIL R5 enq_err act=%0b exp=%0b t=%0t", enq_err, e_err, $time); end
    if (cfg_err !== e_cerr) begin bad = 1;
      $display("FAIL R7 cfg_err act=%0b exp=%0b t=%0t", cfg_err, e_cerr, $time); end
    if (notify !== e_notify) begin bad = 1;
      $display("FAIL R4 notify act=%0b exp=%0b t=%0t", notify, e_notify, $time); end
    if (e_we && mem_addr !== e_addr) begin bad = 1;
      $display("FAIL R2 mem_addr act=%h exp=%h t=%0t", mem_addr, e_addr, $time); end
    if (e_we && mem_wdata !== e_wdata) begin bad = 1;
      $display("FAIL R1 mem_wdata act=%h exp=%h t=%0t", mem_wdata, e_wdata, $time); end
    if (e_notify && notify_qidx !== e_nq) begin bad = 1;
      $display("FAIL R4 notify_qidx act=%0d exp=%0d t=%0t", notify_qidx, e_nq, $time); end
    if (bad) n_bad++;
  end

  task automatic dchk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cfg(int q, logic [31:0] b, int lg);
    cfg_we = 1; cfg_qidx = QI'(q); cfg_base = b; cfg_log2 = 5'(lg);
    step();
    cfg_we = 0;
  endtask

  task automatic do_enq(int q, logic [30:0] d);
    enq_valid = 1; enq_qidx = QI'(q); enq_data = d;
    step();
    enq_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    dchk(!mem_we && !notify && !enq_err && !cfg_err, "R10 outputs idle after reset",
         {28'd0, mem_we, notify, enq_err, cfg_err}, 32'd0);

    do_enq(3, 31'h5);
    dchk(enq_err && !mem_we, "R5 enqueue to unconfigured queue", {31'd0, enq_err}, 32'd1);

    do_cfg(1, 32'h1000, 4);
    do_cfg(10, 32'h2000, 5);
    do_enq(1, 31'h11);
    dchk(mem_addr == 32'h1000, "R2 first slot address", mem_addr, 32'h1000);
    dchk(mem_wdata == {1'b1, 31'h11}, "R1 entry word", mem_wdata, {1'b1, 31'h11});
    step();
    dchk(notify && notify_qidx == 5'd1, "R4 notify after write", {27'd0, notify_qidx}, 32'd1);

    do_enq(1, 31'h12);
    do_enq(10, 31'h77);
    dchk(mem_addr == 32'h2000, "R2 second queue independent", mem_addr, 32'h2000);
    do_enq(1, 31'h13);
    do_enq(1, 31'h14);
    dchk(mem_addr == 32'h100C && mem_wdata[31], "R3 last slot before wrap", mem_addr, 32'h100C);
    do_enq(1, 31'h15);
    dchk(mem_addr == 32'h1000, "R3 index wraps", mem_addr, 32'h1000);
    dchk(mem_wdata[31] == 1'b0, "R3 generation flips on wrap", {31'd0, mem_wdata[31]}, 32'd0);

    do_cfg(7, 32'h4000, 4);
    dchk(cfg_err, "R6 reserved priority config refused", {31'd0, cfg_err}, 32'd1);
    do_enq(7, 31'h1);
    dchk(enq_err && !mem_we, "R6 reserved priority enqueue dropped", {31'd0, enq_err}, 32'd1);

    do_cfg(1, 32'h9000, 3);
    dchk(cfg_err, "R7 size below range refused", {31'd0, cfg_err}, 32'd1);
    do_cfg(1, 32'h9000, 13);
    dchk(cfg_err, "R7 size above range refused", {31'd0, cfg_err}, 32'd1);
    do_enq(1, 31'h16);
    dchk(mem_addr == 32'h1004 && !mem_wdata[31], "R7 refused config leaves queue", mem_addr, 32'h1004);

    do_cfg(1, 32'h3000, 4);
    do_enq(1, 31'h17);
    dchk(mem_addr == 32'h3000 && mem_wdata[31], "R9 reconfig restarts", mem_addr, 32'h3000);

    cfg_we = 1; cfg_qidx = 5'd10; cfg_base = 32'h2000; cfg_log2 = 5'd5;
    enq_valid = 1; enq_qidx = 5'd10; enq_data = 31'h3;
    step();
    cfg_we = 0; enq_valid = 0;
    dchk(mem_addr == 32'h2004, "R9 same-cycle enqueue uses old state", mem_addr, 32'h2004);
    do_enq(10, 31'h4);
    dchk(mem_addr == 32'h2000, "R9 config applied after same-cycle enqueue", mem_addr, 32'h2000);

    do_cfg(10, 32'h0, 0);
    do_enq(10, 31'h5);
    dchk(enq_err, "R5 size zero disables queue", {31'd0, enq_err}, 32'd1);

    for (int q = 0; q < NQ; q++)
      if (q % 8 != 7) do_cfg(q, 32'(q) << 16, 4 + q % 3);
    for (int k = 0; k < 600; k++) begin
      seed = seed * 1103515245 + 12345;
      enq_valid = seed[20];
      enq_qidx  = QI'(seed[27:23]);
      enq_data  = {seed[30:0]} ^ 31'h2A5A5A5;
      cfg_we    = (seed[14:11] == 4'd0);
      cfg_qidx  = QI'(seed[9:5]);
      cfg_log2  = 5'(seed[4:1] % 15);
      cfg_base  = {seed[18:15], 28'd0};
      step();
    end
    enq_valid = 0; cfg_we = 0;
    step();

    do_cfg(2, 32'h5000, 4);
    clear_all = 1; enq_valid = 1; enq_qidx = 5'd2; enq_data = 31'h9;
    step();
    clear_all = 0; enq_valid = 0;
    dchk(enq_err && !mem_we, "R8 enqueue with clear dropped", {31'd0, enq_err}, 32'd1);
    do_enq(1, 31'h9);
    dchk(enq_err && !mem_we, "R8 queues disabled after clear", {31'd0, enq_err}, 32'd1);
    step();
    finish_run();
  end
endmodule